// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block drives the pins of an asynchronous 8-bit NAND flash device. It runs one bus cycle per request: command latch, address latch, data write or data read. A client hands over a request on a valid/ready interface. The request carries the cycle kind, the byte to drive and an optional request to wait for the device to become ready. When the cycle ends, the block returns a one-cycle response pulse with the captured read byte and a timeout flag.

Every timing interval is a count of system clock cycles held in its own writable register: strobe low time, strobe high time, latch-enable setup and hold, chip-enable setup and hold, data setup and hold, write-to-busy window, read access, chip-enable access, ready-to-read delay and busy timeout. A count of zero is treated as one cycle. Each cycle runs through three phases with the device selected: setup, strobe and hold. The lengths of these phases are the largest of the intervals that apply to the cycle kind. After a write-type cycle with a wait request, the block first lets the write-to-busy window expire. It then polls the synchronised ready/busy line until the device reports ready, and applies the ready-to-read delay before it responds.

Top module: `nand_cycle_seq`

## Requirements
- R1: While reset is held and directly after it, chip enable, write strobe and read strobe are high, both latch enables and the data drive enable are low, `req_ready` is high and `resp_valid` is low.
- R2: The timing registers are selected by `cfg_idx`: 0 strobe low, 1 strobe high, 2 latch setup, 3 latch hold, 4 CE setup, 5 CE hold, 6 data setup, 7 data hold, 8 write-to-busy, 9 read access, 10 CE access, 11 ready-to-read, 12 busy timeout. Their reset values are 1,1,1,1,2,1,1,1,20,4,10,2,1000. A stored zero acts as one.
- R3: `req_kind` encodes 0 command, 1 address, 2 data write and 3 data read. In a write-type cycle the write strobe is low for exactly the strobe-low count, and it never overlaps the read strobe.
- R4: In a command cycle the command latch enable is high for the whole time chip enable is low, and the address latch enable stays low.
- R5: In an address cycle the address latch enable is high for the whole time chip enable is low, and the command latch enable stays low.
- R6: Chip enable is low for setup+strobe+hold cycles. Setup is the maximum of CE setup, data setup and (command/address only) latch setup. Hold is the maximum of CE hold, strobe high, data hold and (command/address only) latch hold. The strobe falls in setup cycle S+1.
- R7: For write-type cycles the data drive enable is high for exactly the chip-enable-low window and `nand_dq_o` carries the request byte during all of it. It is never high in a read cycle or while the read strobe is low.
- R8: In a read cycle the read strobe is low for the maximum of the strobe-low count, the read-access count and (CE access minus CE setup, at least 1). The byte on `nand_dq_i` in the last strobe-low cycle is returned in `resp_rdata`. Hold is the maximum of CE hold and strobe high.
- R9: Without a wait request, the response pulse appears in the cycle after hold ends, and a new request can be accepted in that cycle.
- R10: With a wait request, the write-to-busy window follows the hold phase. Polling begins only after the window. The response comes exactly ready-to-read cycles after the first poll cycle that sees the synchronised ready line high.
- R11: If the ready line stays low for the busy-timeout count of poll cycles, the block responds with `resp_err` high. Otherwise `resp_err` is low.
- R12: `req_ready` is low from acceptance until the response cycle, and requests presented in that time are ignored. `resp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Timing register write strobe |
| cfg_idx | input | 4 | Timing register select |
| cfg_wdata | input | TO_W | Timing register write value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 2 | Cycle kind |
| req_wdata | input | DQ_W | Byte for write-type cycles |
| req_wait | input | 1 | Wait for device ready after the cycle |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DQ_W | Byte captured in the last read cycle |
| resp_err | output | 1 | Busy timeout occurred |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | DQ_W | Data bus output value |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_i | input | DQ_W | Data bus input value |
| nand_rb_n | input | 1 | Ready/busy from device, low when busy |

## Verification
The hardest situation to reach is the order between the write-to-busy window, the device busy period seen through the synchroniser, the poll timeout and the ready-to-read delay. A response that is one cycle too early or too late looks normal at the pins. The bench models the device ready line from its own observation of the write strobe rising. It delays the busy drop by a random amount inside the window and keeps the line low for a random length. It then predicts the exact response cycle. A directed case holds the line low past a short timeout. Captured read data is only made valid once both access counts have elapsed, so a capture that comes too early returns the inverted byte.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   typedef enum logic [1:0] {
      OP_CMD   = 2'd0,
      OP_ADDR  = 2'd1,
      OP_WRITE = 2'd2,
      OP_READ  = 2'd3
   } op_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STROBE,
      ST_HOLD,
      ST_BUSYWIN,
      ST_POLL,
      ST_RRDLY
   } seq_state_e;

   // register select values
   localparam int T_STRB_LO   = 0;
   localparam int T_STRB_HI   = 1;
   localparam int T_LAT_SU    = 2;
   localparam int T_LAT_HD    = 3;
   localparam int T_CE_SU     = 4;
   localparam int T_CE_HD     = 5;
   localparam int T_DAT_SU    = 6;
   localparam int T_DAT_HD    = 7;
   localparam int T_WR2BUSY   = 8;
   localparam int T_RD_ACC    = 9;
   localparam int T_CE_ACC    = 10;
   localparam int T_RDY2RD    = 11;
   localparam int T_BUSY_TO   = 12;
   localparam int NUM_CNT     = 12;
   localparam int NUM_TIMING  = 13;
   localparam int IDX_W       = $clog2(NUM_TIMING);

   // reset values, sized for a 100 MHz system clock
   function automatic int timing_default(int idx);
      case (idx)
         T_CE_SU:   return 2;
         T_WR2BUSY: return 20;
         T_RD_ACC:  return 4;
         T_CE_ACC:  return 10;
         T_RDY2RD:  return 2;
         T_BUSY_TO: return 1000;
         default:   return 1;
      endcase
   endfunction

endpackage

// File: rtl/nand_timing_regs.sv
module nand_timing_regs
   import nand_seq_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int TO_W  = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cfg_wr,
   input  logic [IDX_W-1:0]                cfg_idx,
   input  logic [TO_W-1:0]                 cfg_wdata,
   output logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_eff,
   output logic [TO_W-1:0]                 tout_eff
);

   logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
   logic [TO_W-1:0]               tout_q;

   for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q[g] <= CNT_W'(timing_default(g));
         else if (cfg_wr && cfg_idx == IDX_W'(g))
            cnt_q[g] <= cfg_wdata[CNT_W-1:0];
      end
      // zero stored means one cycle
      assign cnt_eff[g] = (cnt_q[g] == '0) ? CNT_W'(1) : cnt_q[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tout_q <= TO_W'(timing_default(T_BUSY_TO));
      else if (cfg_wr && cfg_idx == IDX_W'(T_BUSY_TO))
         tout_q <= cfg_wdata;
   end

   assign tout_eff = (tout_q == '0) ? TO_W'(1) : tout_q;

endmodule

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] len,
   output logic         expired
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= len - W'(1);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - W'(1);
   end

   // a phase of len cycles ends in the cycle the count reaches zero
   assign expired = (cnt_q == '0);

   AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> len != '0); // R2

endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rb_n,
   output logic dev_ready
);

   if (STAGES == 0) begin : g_direct
      assign dev_ready = rb_n;
   end else begin : g_chain
      logic [STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sync_q <= '1;
         else
            sync_q <= {sync_q[STAGES-2+((STAGES==1)?1:0):0], rb_n};
      end
      assign dev_ready = sync_q[STAGES-1];
   end

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
   import nand_seq_pkg::*;
#(
   parameter int CNT_W          = 8,
   parameter int TO_W           = 16,
   parameter int DQ_W           = 8,
   parameter int RB_SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [3:0]       cfg_idx,
   input  logic [TO_W-1:0]  cfg_wdata,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [1:0]       req_kind,
   input  logic [DQ_W-1:0]  req_wdata,
   input  logic             req_wait,
   output logic             resp_valid,
   output logic [DQ_W-1:0]  resp_rdata,
   output logic             resp_err,
   output logic             nand_ce_n,
   output logic             nand_cle,
   output logic             nand_ale,
   output logic             nand_we_n,
   output logic             nand_re_n,
   output logic [DQ_W-1:0]  nand_dq_o,
   output logic             nand_dq_oe,
   input  logic [DQ_W-1:0]  nand_dq_i,
   input  logic             nand_rb_n
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 4) begin : g_bad_cnt
      $error("CNT_W must be at least 4");
   end
   if (TO_W < CNT_W || TO_W > 32) begin : g_bad_to
      $error("TO_W must lie between CNT_W and 32");
   end
   if (IDX_W != 4) begin : g_bad_idx
      $error("register select width must be 4");
   end
   if (RB_SYNC_STAGES < 0 || RB_SYNC_STAGES > 4) begin : g_bad_sync
      $error("RB_SYNC_STAGES must be 0 to 4");
   end

   // ---------------- timing registers ----------------
   logic [NUM_CNT-1:0][CNT_W-1:0] t_eff;
   logic [TO_W-1:0]               tout_eff;

   nand_timing_regs #(.CNT_W(CNT_W), .TO_W(TO_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_wr),
      .cfg_idx  (cfg_idx),
      .cfg_wdata(cfg_wdata),
      .cnt_eff  (t_eff),
      .tout_eff (tout_eff)
   );

   // ---------------- ready line ----------------
   logic dev_ready;

   nand_rb_sync #(.STAGES(RB_SYNC_STAGES)) u_rb (
      .clk      (clk),
      .rst_n    (rst_n),
      .rb_n     (nand_rb_n),
      .dev_ready(dev_ready)
   );

   // ---------------- request state ----------------
   seq_state_e      st_q, st_nxt;
   op_kind_e        kind_q;
   logic [DQ_W-1:0] wdata_q;
   logic            wait_q;

   logic accept;
   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_ready && req_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q  <= OP_CMD;
         wdata_q <= '0;
         wait_q  <= 1'b0;
      end else if (accept) begin
         kind_q  <= op_kind_e'(req_kind);
         wdata_q <= req_wdata;
         wait_q  <= req_wait;
      end
   end

   // ---------------- phase lengths ----------------
   function automatic logic [CNT_W-1:0] max2(logic [CNT_W-1:0] a, logic [CNT_W-1:0] b);
      return (a > b) ? a : b;
   endfunction

   op_kind_e         k_sel;
   logic             k_read, k_latch;
   logic [CNT_W-1:0] s_len, l_len, h_len, cea_rem;

   always_comb begin
      k_sel   = req_ready ? op_kind_e'(req_kind) : kind_q;
      k_read  = (k_sel == OP_READ);
      k_latch = (k_sel == OP_CMD) || (k_sel == OP_ADDR);
      s_len   = k_read ? t_eff[T_CE_SU]
                       : max2(max2(t_eff[T_CE_SU], t_eff[T_DAT_SU]),
                              k_latch ? t_eff[T_LAT_SU] : ONE);
      cea_rem = (t_eff[T_CE_ACC] > s_len) ? t_eff[T_CE_ACC] - s_len : ONE;
      l_len   = k_read ? max2(max2(t_eff[T_STRB_LO], t_eff[T_RD_ACC]), cea_rem)
                       : t_eff[T_STRB_LO];
      h_len   = k_read ? max2(t_eff[T_CE_HD], t_eff[T_STRB_HI])
                       : max2(max2(t_eff[T_CE_HD], t_eff[T_STRB_HI]),
                              max2(t_eff[T_DAT_HD], k_latch ? t_eff[T_LAT_HD] : ONE));
   end

   // ---------------- timers ----------------
   logic             ph_load, ph_exp, to_load, to_exp;
   logic [CNT_W-1:0] ph_len;

   nand_phase_timer #(.W(CNT_W)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (ph_load),
      .len    (ph_len),
      .expired(ph_exp)
   );

   nand_phase_timer #(.W(TO_W)) u_tout (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (to_load),
      .len    (tout_eff),
      .expired(to_exp)
   );

   // ---------------- sequencing ----------------
   logic finish, fin_err, capture;

   always_comb begin
      st_nxt  = st_q;
      ph_load = 1'b0;
      ph_len  = ONE;
      to_load = 1'b0;
      finish  = 1'b0;
      fin_err = 1'b0;
      capture = 1'b0;
      case (st_q)
         ST_IDLE: if (req_valid) begin
            st_nxt  = ST_SETUP;
            ph_load = 1'b1;
            ph_len  = s_len;
         end
         ST_SETUP: if (ph_exp) begin
            st_nxt  = ST_STROBE;
            ph_load = 1'b1;
            ph_len  = l_len;
         end
         ST_STROBE: if (ph_exp) begin
            capture = k_read;
            st_nxt  = ST_HOLD;
            ph_load = 1'b1;
            ph_len  = h_len;
         end
         ST_HOLD: if (ph_exp) begin
            if (wait_q) begin
               st_nxt  = ST_BUSYWIN;
               ph_load = 1'b1;
               ph_len  = t_eff[T_WR2BUSY];
            end else begin
               st_nxt = ST_IDLE;
               finish = 1'b1;
            end
         end
         ST_BUSYWIN: if (ph_exp) begin
            st_nxt  = ST_POLL;
            to_load = 1'b1;
         end
         ST_POLL: begin
            if (dev_ready) begin
               st_nxt  = ST_RRDLY;
               ph_load = 1'b1;
               ph_len  = t_eff[T_RDY2RD];
            end else if (to_exp) begin
               st_nxt  = ST_IDLE;
               finish  = 1'b1;
               fin_err = 1'b1;
            end
         end
         ST_RRDLY: if (ph_exp) begin
            st_nxt = ST_IDLE;
            finish = 1'b1;
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         resp_valid <= 1'b0;
         resp_err   <= 1'b0;
         resp_rdata <= '0;
      end else begin
         st_q       <= st_nxt;
         resp_valid <= finish;
         if (finish)
            resp_err <= fin_err;
         if (capture)
            resp_rdata <= nand_dq_i;
      end
   end

   // ---------------- pin decode ----------------
   logic selected;
   assign selected   = (st_q == ST_SETUP) || (st_q == ST_STROBE) || (st_q == ST_HOLD);
   assign nand_ce_n  = !selected;
   assign nand_cle   = selected && (kind_q == OP_CMD);
   assign nand_ale   = selected && (kind_q == OP_ADDR);
   assign nand_dq_oe = selected && (kind_q != OP_READ);
   assign nand_dq_o  = wdata_q;
   assign nand_we_n  = !((st_q == ST_STROBE) && (kind_q != OP_READ));
   assign nand_re_n  = !((st_q == ST_STROBE) && (kind_q == OP_READ));

   // ---------------- assertions ----------------
   AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n)); // R3

   AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale)); // R4

   AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n || !nand_re_n) |-> !nand_ce_n); // R6

   AST_WE_RISE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nand_we_n) |-> (!nand_ce_n && $stable(nand_cle) && $stable(nand_ale)
                            && $stable(nand_dq_o) && nand_dq_oe)); // R7

   AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> !nand_dq_oe); // R7

   AST_ERR_WITH_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(resp_err) |-> resp_valid); // R11

   AST_READY_DROP_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_ready) |-> $past(req_valid)); // R12

   AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid); // R12

endmodule

// File: tb/test_nand_cycle_seq.sv
module test_nand_cycle_seq;

   localparam int CNT_W = 8;
   localparam int TO_W  = 16;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            cfg_wr;
   logic [3:0]      cfg_idx;
   logic [TO_W-1:0] cfg_wdata;
   logic            req_valid, req_ready, req_wait;
   logic [1:0]      req_kind;
   logic [7:0]      req_wdata;
   logic            resp_valid, resp_err;
   logic [7:0]      resp_rdata;
   logic            nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0]      nand_dq_o, nand_dq_i;
   logic            nand_rb_n;

   always #10 clk = ~clk;

   nand_cycle_seq i_nand_cycle_seq (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_wdata(req_wdata), .req_wait(req_wait),
      .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_err(resp_err),
      .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
      .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
      .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n)
   );

   int n_vec = 0;
   int n_bad = 0;
   int cfg_m [13];

   task automatic chk(string req, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      report();
      $finish;
   end

   function automatic int ef(int v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic int mx(int a, int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int exp_setup(int k);
      if (k == 3) return ef(cfg_m[4]);
      return mx(mx(ef(cfg_m[4]), ef(cfg_m[6])), (k < 2) ? ef(cfg_m[2]) : 1);
   endfunction

   function automatic int exp_strobe(int k, int s);
      int rem;
      if (k != 3) return ef(cfg_m[0]);
      rem = (ef(cfg_m[10]) > s) ? ef(cfg_m[10]) - s : 1;
      return mx(mx(ef(cfg_m[0]), ef(cfg_m[9])), rem);
   endfunction

   function automatic int exp_hold(int k);
      if (k == 3) return mx(ef(cfg_m[5]), ef(cfg_m[1]));
      return mx(mx(ef(cfg_m[5]), ef(cfg_m[1])),
                mx(ef(cfg_m[7]), (k < 2) ? ef(cfg_m[3]) : 1));
   endfunction

   task automatic cfg_write(int idx, int val);
      @(negedge clk);
      cfg_wr    = 1'b1;
      cfg_idx   = 4'(idx);
      cfg_wdata = TO_W'(val);
      cfg_m[idx] = val;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   // one bus cycle with full pin tally; d/blen shape the device busy period
   task automatic do_op(int k, logic [7:0] b, bit wt, int d, int blen);
      int s, l, h, base, p0, p, n_exp, t0e, n, got_n, t0;
      int we_lo, first_we, re_lo, ce_lo, cle_c, ale_c, oe_c, mism, rdy_hi;
      bit done, exp_err, got_err, prev_we;
      logic [7:0] got_rd;
      s = exp_setup(k);
      l = exp_strobe(k, s);
      h = exp_hold(k);
      base = s + l + h;
      t0e = s + l + 1;
      p0 = base + ef(cfg_m[8]) + 1;
      exp_err = 1'b0;
      if (!wt) n_exp = base + 1;
      else if (t0e + d + blen + 2 > p0 + ef(cfg_m[12]) - 1) begin
         exp_err = 1'b1;
         n_exp = p0 + ef(cfg_m[12]);
      end else begin
         p = mx(p0, t0e + d + blen + 2);
         n_exp = p + ef(cfg_m[11]) + 1;
      end
      @(negedge clk);
      chk("R12 idle ready before request", int'(req_ready), 1);
      req_valid = 1'b1;
      req_kind  = 2'(k);
      req_wdata = b;
      req_wait  = wt;
      nand_rb_n = 1'b1;
      nand_dq_i = ~b;
      n = 0; got_n = -1; t0 = -1; done = 0; prev_we = 1'b1;
      we_lo = 0; first_we = 0; re_lo = 0; ce_lo = 0; cle_c = 0; ale_c = 0;
      oe_c = 0; mism = 0; rdy_hi = 0; got_err = 0; got_rd = '0;
      while (!done && n < 4000) begin
         @(negedge clk);
         n++;
         if (n == 1) begin
            req_kind  = 2'(k ^ 1);   // stray request while busy
            req_wdata = ~b;
         end
         if (n == 2) req_valid = 1'b0;
         if (resp_valid) begin
            done = 1;
            got_n = n;
            got_err = resp_err;
            got_rd = resp_rdata;
         end else if (req_ready) rdy_hi++;
         if (!nand_we_n) begin
            we_lo++;
            if (first_we == 0) first_we = n;
         end
         if (!prev_we && nand_we_n && t0 < 0) t0 = n;
         if (!nand_re_n) re_lo++;
         if (!nand_ce_n) ce_lo++;
         if (nand_cle) cle_c++;
         if (nand_ale) ale_c++;
         if (nand_dq_oe) begin
            oe_c++;
            if (nand_dq_o != b) mism++;
         end
         nand_dq_i = (re_lo >= ef(cfg_m[9]) && ce_lo >= ef(cfg_m[10])) ? b : ~b;
         if (wt && t0 >= 0) nand_rb_n = !(n >= t0 + d && n < t0 + d + blen);
         prev_we = nand_we_n;
      end
      chk("R9/R10/R11 response cycle", got_n, n_exp);
      chk("R12 ready low while busy", rdy_hi, 0);
      chk("R3 write strobe low cycles", we_lo, (k != 3) ? l : 0);
      if (k != 3) chk("R6 strobe falls after setup", first_we, s + 1);
      chk("R8 read strobe low cycles", re_lo, (k == 3) ? l : 0);
      chk("R6 chip enable low cycles", ce_lo, base);
      chk("R4 command latch cycles", cle_c, (k == 0) ? base : 0);
      chk("R5 address latch cycles", ale_c, (k == 1) ? base : 0);
      chk("R7 drive enable cycles", oe_c, (k != 3) ? base : 0);
      chk("R7 driven byte mismatches", mism, 0);
      if (k == 3) chk("R8 read byte", int'(got_rd), int'(b));
      chk("R11 timeout flag", int'(got_err), int'(exp_err));
      @(negedge clk);
      chk("R12 single pulse and idle pins", int'({resp_valid, nand_ce_n, req_ready}), 3);
      if (exp_err) begin
         nand_rb_n = 1'b1;
         repeat (4) @(negedge clk);
      end
   endtask

   initial begin
      int k, bw;
      void'($urandom(32'h5EED));
      for (int i = 0; i < 13; i++) begin
         case (i)
            4: cfg_m[i] = 2;
            8: cfg_m[i] = 20;
            9: cfg_m[i] = 4;
            10: cfg_m[i] = 10;
            11: cfg_m[i] = 2;
            12: cfg_m[i] = 1000;
            default: cfg_m[i] = 1;
         endcase
      end
      rst_n = 1'b0; cfg_wr = 0; cfg_idx = 0; cfg_wdata = 0;
      req_valid = 0; req_kind = 0; req_wdata = 0; req_wait = 0;
      nand_dq_i = 0; nand_rb_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 reset pins", int'({nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}), 56);
      chk("R1 reset handshake", int'({req_ready, resp_valid}), 2);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", int'({nand_ce_n, nand_we_n, nand_re_n, req_ready, resp_valid}), 30);

      // R2 reset defaults, all four kinds
      do_op(0, 8'h70, 0, 0, 0);
      do_op(1, 8'h3C, 0, 0, 0);
      do_op(2, 8'hA5, 0, 0, 0);
      do_op(3, 8'h5A, 0, 0, 0);
      // R10 wait with default window
      do_op(0, 8'h10, 1, 5, 9);
      // R2 zero counts act as one
      cfg_write(0, 0); cfg_write(4, 0); cfg_write(9, 0); cfg_write(10, 0);
      do_op(2, 8'h01, 0, 0, 0);
      do_op(3, 8'hFE, 0, 0, 0);
      // R11 timeout directed
      cfg_write(8, 3); cfg_write(12, 5);
      do_op(1, 8'h22, 1, 0, 300);
      // R10 ready already high when polling starts
      cfg_write(12, 40);
      do_op(2, 8'h44, 1, 1, 0);

      // constrained random
      for (int r = 0; r < 8; r++) begin
         for (int i = 0; i < 12; i++) begin
            if (i == 8) cfg_write(i, $urandom_range(3, 7));
            else if (i == 10) cfg_write(i, $urandom_range(0, 12));
            else cfg_write(i, $urandom_range(0, 4));
         end
         cfg_write(12, 40);
         for (int j = 0; j < 8; j++) begin
            k = $urandom_range(0, 3);
            bw = $urandom_range(0, 255);
            if (k != 3 && $urandom_range(0, 1) == 1)
               do_op(k, 8'(bw), 1, $urandom_range(0, ef(cfg_m[8]) - 2), $urandom_range(1, 12));
            else
               do_op(k, 8'(bw), 0, 0, 0);
         end
      end
      report();
      $finish;
   end

endmodule